// File: doc/BRIEF.md
# Segment Lookaside Buffer

The block is a small, fully associative table of segment translations for a 64-bit effective-address MMU. It covers 256 MB segments only. Each slot holds two 64-bit words. The segment word keeps the effective segment number in bits 63:28 and a valid flag in bit 27. The translation word keeps the virtual segment number in bits 61:12 and the protection and page attributes in bits 11:0. The upper two bits of the translation word hold the segment size, and they are stored but not decoded.

The block has four operations:
- **Lookup** takes an effective address and a user-state flag. One cycle later it returns the translation. A lookup compares against the table as it stood before any update made in the same cycle.
- **Slot write** takes two operands. The slot number comes from the low bits of operand B, and the rest of operand B becomes the segment word.
- **Flush-all** clears every valid flag except the one in slot 0.
- **Flush-by-address** clears the valid flag of the first slot that matches the address.

Each flush reports, through a one-cycle pulse, whether the downstream translation cache must be emptied.

Top module: `seg_lookaside`

## Requirements
- R1: After reset every slot is zero (invalid), and `rspValid`, `rspHit`, `wrErr` and `tlbFlush` are 0. A lookup made right after reset misses.
- R2: A lookup on `lkAddr` builds the key {`lkAddr[63:28]`, bit 27 = 1, bits 26:0 = 0}. A slot hits only when its whole segment word equals the key. On the next clock edge the block sets:
  - `rspValid` = 1 and `rspHit` = 1;
  - `rspVsid` = translation word bits 61:12;
  - `rspAttr` = translation word bits 11:0;
  - `rspSegMask` = 0x0FFFFFFF.

  The lookup compares against the table as it was before any write or flush in the same cycle.
- R3: On a hit, `rspPageBits` is 24 when translation bit 8 is 1, and 12 otherwise.
- R4: On a hit, `rspKey` is translation bit 10 when `lkUser` = 1 and bit 11 when `lkUser` = 0. `rspNoExec` is translation bit 9.
- R5: When several slots hit, the lowest-numbered slot supplies the result.
- R6: On a miss, `rspValid` = 1 and `rspHit` = 0, and `rspVsid`, `rspAttr`, `rspPageBits`, `rspKey`, `rspNoExec` and `rspSegMask` are all 0. A stored segment word with bit 27 clear, or with any of bits 26:12 set, never hits.
- R7: A write with `wrEn` = 1 uses slot `wrOpB[11:0]`. It stores `wrOpB` with bits 11:0 cleared as the segment word, and `wrOpS` unchanged as the translation word, replacing the old contents.
- R8: A write whose slot number `wrOpB[11:0]` is ENTRIES or more changes no slot. It raises `wrErr` for exactly one cycle, on the edge after the request.
- R9: `invAllEn` clears bit 27 of every slot except slot 0. `tlbFlush` pulses on the next edge only if some slot numbered 1 or higher was valid.
- R10: `invAddrEn` runs a match on `invAddr` (same key as R2). On a hit it clears bit 27 of the lowest matching slot and pulses `tlbFlush` on the next edge. On a miss nothing changes and `tlbFlush` stays 0.
- R11: When `wrEn` is 1, both flush requests in the same cycle are ignored and give no `tlbFlush`. When `invAllEn` and `invAddrEn` arrive together, only the flush-all is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 64 | Lookup effective address |
| lkUser | input | 1 | 1 = user (problem) state, 0 = supervisor |
| wrEn | input | 1 | Slot write request |
| wrOpB | input | 64 | Slot number (bits 11:0) and segment word |
| wrOpS | input | 64 | Translation word |
| invAllEn | input | 1 | Flush all slots except slot 0 |
| invAddrEn | input | 1 | Flush the slot matching invAddr |
| invAddr | input | 64 | Address for flush-by-address |
| rspValid | output | 1 | Lookup result present |
| rspHit | output | 1 | Lookup hit |
| rspVsid | output | 50 | Virtual segment number |
| rspPageBits | output | 5 | Page size as address bits (12 or 24) |
| rspKey | output | 1 | Storage key for the current privilege |
| rspNoExec | output | 1 | No-execute flag |
| rspAttr | output | 12 | Raw attribute bits 11:0 |
| rspSegMask | output | 64 | In-segment offset mask |
| wrErr | output | 1 | Invalid-slot write pulse |
| tlbFlush | output | 1 | Translation cache flush pulse |

## Verification
The assertions assume that every request is sampled with `rstN` high and that its inputs are stable at the clock edge. They also assume that ENTRIES is at least 2, so that a slot above slot 0 exists. The stimulus satisfies this by changing inputs only on the falling edge.

The segment numbers are drawn from a pool of eight, so that lookups and flushes both hit and miss. The slot numbers range past the table end, so that rejected writes occur. Write and flush requests are deliberately issued in the same cycle, to exercise the ordering rules.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_SHIFT       = 28;
  localparam int VALID_BIT       = 27;
  localparam int SLOT_FIELD_W    = 12;
  localparam int VSID_LO         = 12;
  localparam int VSID_HI         = 61;
  localparam int VSID_W          = VSID_HI - VSID_LO + 1;
  localparam int KS_BIT          = 11;
  localparam int KP_BIT          = 10;
  localparam int NX_BIT          = 9;
  localparam int LARGE_BIT       = 8;
  localparam int SMALL_PAGE_BITS = 12;
  localparam int LARGE_PAGE_BITS = 24;
  localparam int PAGE_BITS_W     = 5;

  // strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic write;    // store into slot wrIdx
    logic clrAll;   // clear valid of slots 1..N-1
    logic clrOne;   // clear valid of lowest slot matching invAddr
  } seg_strobe_t;
endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [SLOT_FIELD_W-1:0] wrSlotField,
  input  logic                    invAllEn,
  input  logic                    invAddrEn,
  input  logic                    invHit,
  input  logic                    upperValid,
  output seg_strobe_t             st,
  output logic [IDX_W-1:0]        wrIdx,
  output logic                    wrErr,
  output logic                    tlbFlush
);
  logic slotOk;
  logic badSlot;
  logic flushNow;

  assign slotOk  = (int'(wrSlotField) < ENTRIES);
  assign badSlot = wrEn && !slotOk;
  assign wrIdx   = wrSlotField[IDX_W-1:0];

  // write wins over both flushes; flush-all wins over flush-by-address
  always_comb begin
    st.write  = wrEn && slotOk;
    st.clrAll = !wrEn && invAllEn;
    st.clrOne = !wrEn && !invAllEn && invAddrEn && invHit;
    flushNow  = (st.clrAll && upperValid) || st.clrOne;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrErr    <= 1'b0;
      tlbFlush <= 1'b0;
    end else begin
      wrErr    <= badSlot;
      tlbFlush <= flushNow;
    end
  end

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> ($past(wrEn) && int'($past(wrSlotField)) >= ENTRIES));   // R8
  AST_FLUSH_NEEDS_INV: assert property (@(posedge clk) disable iff (!rstN)
    tlbFlush |-> ($past(invAllEn) || $past(invAddrEn)));                // R10
  AST_WRITE_BLOCKS_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !tlbFlush);                                                // R11
endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seg_strobe_t            st,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [63:SLOT_FIELD_W] wrEsidHi,
  input  logic [63:0]            wrOpS,
  input  logic                   lkValid,
  input  logic [63:SEG_SHIFT]    lkSeg,
  input  logic                   lkUser,
  input  logic [63:SEG_SHIFT]    invSeg,
  output logic                   invHit,
  output logic                   upperValid,
  output logic                   rspValid,
  output logic                   rspHit,
  output logic [VSID_W-1:0]      rspVsid,
  output logic [PAGE_BITS_W-1:0] rspPageBits,
  output logic                   rspKey,
  output logic                   rspNoExec,
  output logic [11:0]            rspAttr,
  output logic [63:0]            rspSegMask
);
  localparam logic [63:0] SEG_MASK = (64'd1 << SEG_SHIFT) - 64'd1;

  logic [63:0]        esidQ [ENTRIES];
  logic [63:0]        vsidQ [ENTRIES];
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] invMatch;
  logic [ENTRIES-1:0] validVec;
  logic [63:0]        lkKey;
  logic [63:0]        invKey;
  logic               lkAny;
  logic [IDX_W-1:0]   lkSel;
  logic [IDX_W-1:0]   invSel;
  logic [63:0]        selV;
  logic               hitNow;

  assign lkKey  = {lkSeg,  1'b1, {VALID_BIT{1'b0}}};
  assign invKey = {invSeg, 1'b1, {VALID_BIT{1'b0}}};

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign lkMatch[g]  = (esidQ[g] == lkKey);
    assign invMatch[g] = (esidQ[g] == invKey);
    assign validVec[g] = esidQ[g][VALID_BIT];
  end

  assign upperValid = |validVec[ENTRIES-1:1];

  // lowest matching slot wins
  always_comb begin
    lkAny  = 1'b0;
    lkSel  = '0;
    invHit = 1'b0;
    invSel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        lkAny = 1'b1;
        lkSel = IDX_W'(i);
      end
      if (invMatch[i]) begin
        invHit = 1'b1;
        invSel = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        esidQ[i] <= '0;
        vsidQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (st.write && wrIdx == IDX_W'(i)) begin
          esidQ[i] <= {wrEsidHi, {SLOT_FIELD_W{1'b0}}};
          vsidQ[i] <= wrOpS;
        end else if ((st.clrAll && i != 0) || (st.clrOne && invSel == IDX_W'(i))) begin
          esidQ[i][VALID_BIT] <= 1'b0;
        end
      end
    end
  end

  assign selV   = vsidQ[lkSel];
  assign hitNow = lkValid && lkAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspVsid     <= '0;
      rspPageBits <= '0;
      rspKey      <= 1'b0;
      rspNoExec   <= 1'b0;
      rspAttr     <= '0;
      rspSegMask  <= '0;
    end else begin
      rspValid    <= lkValid;
      rspHit      <= hitNow;
      rspVsid     <= hitNow ? selV[VSID_HI:VSID_LO] : '0;
      rspPageBits <= !hitNow ? '0 :
                     selV[LARGE_BIT] ? PAGE_BITS_W'(LARGE_PAGE_BITS)
                                     : PAGE_BITS_W'(SMALL_PAGE_BITS);
      rspKey      <= hitNow && (lkUser ? selV[KP_BIT] : selV[KS_BIT]);
      rspNoExec   <= hitNow && selV[NX_BIT];
      rspAttr     <= hitNow ? selV[11:0] : '0;
      rspSegMask  <= hitNow ? SEG_MASK : '0;
    end
  end

  AST_SLOT0_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    st.clrAll |=> $stable(esidQ[0]));                                   // R9
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    st.write |=> esidQ[$past(wrIdx)] == {$past(wrEsidHi), {SLOT_FIELD_W{1'b0}}}); // R7
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspVsid == '0 && rspAttr == '0 && !rspKey && !rspNoExec)); // R6
  AST_PAGE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspPageBits == PAGE_BITS_W'(SMALL_PAGE_BITS) ||
                rspPageBits == PAGE_BITS_W'(LARGE_PAGE_BITS)));         // R3
  AST_HIT_IS_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid);                                               // R2
endmodule

// File: rtl/seg_lookaside.sv
module seg_lookaside
  import seg_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lkValid,
  input  logic [63:0]            lkAddr,
  input  logic                   lkUser,
  input  logic                   wrEn,
  input  logic [63:0]            wrOpB,
  input  logic [63:0]            wrOpS,
  input  logic                   invAllEn,
  input  logic                   invAddrEn,
  input  logic [63:0]            invAddr,
  output logic                   rspValid,
  output logic                   rspHit,
  output logic [VSID_W-1:0]      rspVsid,
  output logic [PAGE_BITS_W-1:0] rspPageBits,
  output logic                   rspKey,
  output logic                   rspNoExec,
  output logic [11:0]            rspAttr,
  output logic [63:0]            rspSegMask,
  output logic                   wrErr,
  output logic                   tlbFlush
);
  localparam int IDX_W = $clog2(ENTRIES);

  seg_strobe_t      st;
  logic [IDX_W-1:0] wrIdx;
  logic             invHit;
  logic             upperValid;

  seg_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrSlotField(wrOpB[SLOT_FIELD_W-1:0]),
    .invAllEn(invAllEn), .invAddrEn(invAddrEn),
    .invHit(invHit), .upperValid(upperValid),
    .st(st), .wrIdx(wrIdx), .wrErr(wrErr), .tlbFlush(tlbFlush)
  );

  seg_datapath #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrIdx(wrIdx),
    .wrEsidHi(wrOpB[63:SLOT_FIELD_W]), .wrOpS(wrOpS),
    .lkValid(lkValid), .lkSeg(lkAddr[63:SEG_SHIFT]), .lkUser(lkUser),
    .invSeg(invAddr[63:SEG_SHIFT]),
    .invHit(invHit), .upperValid(upperValid),
    .rspValid(rspValid), .rspHit(rspHit), .rspVsid(rspVsid),
    .rspPageBits(rspPageBits), .rspKey(rspKey), .rspNoExec(rspNoExec),
    .rspAttr(rspAttr), .rspSegMask(rspSegMask)
  );
endmodule

// File: tb/seg_lookaside_bench.sv
module seg_lookaside_bench;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 0, lkUser = 0, wrEn = 0, invAllEn = 0, invAddrEn = 0;
  logic [63:0] lkAddr = 0, wrOpB = 0, wrOpS = 0, invAddr = 0;
  logic        rspValid, rspHit, rspKey, rspNoExec, wrErr, tlbFlush;
  logic [49:0] rspVsid;
  logic [4:0]  rspPageBits;
  logic [11:0] rspAttr;
  logic [63:0] rspSegMask;

  seg_lookaside #(.ENTRIES(N)) u_seg_lookaside (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr), .lkUser(lkUser),
    .wrEn(wrEn), .wrOpB(wrOpB), .wrOpS(wrOpS), .invAllEn(invAllEn),
    .invAddrEn(invAddrEn), .invAddr(invAddr), .rspValid(rspValid), .rspHit(rspHit),
    .rspVsid(rspVsid), .rspPageBits(rspPageBits), .rspKey(rspKey),
    .rspNoExec(rspNoExec), .rspAttr(rspAttr), .rspSegMask(rspSegMask),
    .wrErr(wrErr), .tlbFlush(tlbFlush)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  logic [63:0] mSeg [N];
  logic [63:0] mXl  [N];
  logic        eValid, eHit, eKey, eNx, eErr, eFlush;
  logic [49:0] eVsid;
  logic [4:0]  ePage;
  logic [11:0] eAttr;
  logic [63:0] eMask, key, xl;
  int          compared = 0, mismatched = 0, cycles = 0;
  string       curReq = "R1";
  bit          done = 0;

  function automatic logic [63:0] keyOf(input logic [63:0] a);
    return {a[63:28], 28'h0} | (64'd1 << 27);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < N; n++) begin mSeg[n] = 0; mXl[n] = 0; end
      {eValid, eHit, eKey, eNx, eErr, eFlush} = '0;
      eVsid = 0; ePage = 0; eAttr = 0; eMask = 0;
    end else begin
      eValid = lkValid; eHit = 0; eVsid = 0; ePage = 0; eKey = 0; eNx = 0; eAttr = 0; eMask = 0;
      if (lkValid) begin
        key = keyOf(lkAddr);
        for (int n = 0; n < N; n++)
          if (!eHit && mSeg[n] == key) begin eHit = 1; xl = mXl[n]; end
        if (eHit) begin
          eVsid = xl[61:12];
          ePage = xl[8] ? 5'd24 : 5'd12;
          eKey  = lkUser ? xl[10] : xl[11];
          eNx   = xl[9];
          eAttr = xl[11:0];
          eMask = 64'h0FFF_FFFF;
        end
      end
      eErr = wrEn && (wrOpB[11:0] >= 12'(N));
      eFlush = 0;
      if (wrEn) begin
        if (!eErr) begin
          mSeg[int'(wrOpB[11:0])] = {wrOpB[63:12], 12'h0};
          mXl[int'(wrOpB[11:0])]  = wrOpS;
        end
      end else if (invAllEn) begin
        for (int n = 1; n < N; n++)
          if (mSeg[n][27]) begin eFlush = 1; mSeg[n][27] = 0; end
      end else if (invAddrEn) begin
        key = keyOf(invAddr);
        for (int n = 0; n < N; n++)
          if (!eFlush && mSeg[n] == key) begin eFlush = 1; mSeg[n][27] = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if ({rspValid, rspHit, rspVsid, rspPageBits, rspKey, rspNoExec, rspAttr, rspSegMask, wrErr, tlbFlush} !==
          {eValid, eHit, eVsid, ePage, eKey, eNx, eAttr, eMask, eErr, eFlush}) begin
        mismatched++;
        $display("FAIL %s t=%0t got v%0b h%0b vsid=%h pg=%0d k%0b nx%0b attr=%h mask=%h err%0b fl%0b exp v%0b h%0b vsid=%h pg=%0d k%0b nx%0b attr=%h mask=%h err%0b fl%0b",
          curReq, $time, rspValid, rspHit, rspVsid, rspPageBits, rspKey, rspNoExec, rspAttr, rspSegMask, wrErr, tlbFlush,
          eValid, eHit, eVsid, ePage, eKey, eNx, eAttr, eMask, eErr, eFlush);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [63:0] segB(input int seg, input bit v, input int slot);
    return (64'h0000_00A0_0000_0000 + (64'(seg) << 28)) | (v ? (64'd1 << 27) : 64'd0) | 64'(slot);
  endfunction

  task automatic idle(); @(negedge clk); lkValid = 0; wrEn = 0; invAllEn = 0; invAddrEn = 0; endtask
  task automatic wr(input logic [63:0] b, input logic [63:0] s);
    @(negedge clk); wrEn = 1; wrOpB = b; wrOpS = s; idle();
  endtask
  task automatic look(input int seg, input bit user);
    @(negedge clk); lkValid = 1; lkUser = user;
    lkAddr = segB(seg, 0, 0) | 64'h0ABC_DEF5; idle();
  endtask

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1;
    look(1, 0);
    curReq = "R7"; wr(segB(1, 1, 3), 64'h0012_3456_789A_B000 | 64'h0A5);
    curReq = "R2"; look(1, 0); look(1, 1);
    curReq = "R3"; wr(segB(2, 1, 5), 64'h0000_0000_0000_1000 | 64'h100); look(2, 0);
    curReq = "R4"; wr(segB(3, 1, 6), 64'h0000_0000_0000_2000 | 64'h800); look(3, 0); look(3, 1);
    wr(segB(3, 1, 6), 64'h0000_0000_0000_2000 | 64'h600); look(3, 0); look(3, 1);
    curReq = "R5"; wr(segB(4, 1, 9), 64'h0000_0000_0009_9000); wr(segB(4, 1, 2), 64'h0000_0000_0002_2000); look(4, 0);
    curReq = "R6"; wr(segB(5, 0, 7), 64'h0000_0000_0007_7000); look(5, 0);
    wr(segB(6, 1, 8) | 64'h0010_0000, 64'h0000_0000_0008_8000); look(6, 0); look(7, 0);
    curReq = "R8"; wr(segB(1, 1, N), 64'hFFFF); wr(segB(1, 1, 12'hFFF), 64'hFFFF); look(1, 0);
    curReq = "R10"; @(negedge clk); invAddrEn = 1; invAddr = segB(4, 0, 0); idle(); look(4, 0);
    @(negedge clk); invAddrEn = 1; invAddr = segB(7, 0, 0); idle();
    curReq = "R11"; @(negedge clk); wrEn = 1; wrOpB = segB(7, 1, 10); wrOpS = 64'h7000; invAllEn = 1; idle(); look(7, 0);
    @(negedge clk); invAllEn = 1; invAddrEn = 1; invAddr = segB(1, 0, 0); idle(); look(1, 0);
    curReq = "R9"; wr(segB(0, 1, 0), 64'h0000_0000_0000_3000); wr(segB(1, 1, 3), 64'h4000);
    @(negedge clk); invAllEn = 1; idle(); look(0, 0); look(1, 0);
    @(negedge clk); invAllEn = 1; idle();
    curReq = "R2";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      lkValid = $urandom_range(0, 1); lkUser = $urandom_range(0, 1);
      lkAddr = segB($urandom_range(0, 7), 0, 0) | 64'($urandom);
      wrEn = ($urandom_range(0, 3) == 0);
      wrOpB = segB($urandom_range(0, 7), $urandom_range(0, 9) != 0, $urandom_range(0, N + 5));
      wrOpS = {$urandom, $urandom};
      invAllEn = ($urandom_range(0, 19) == 0);
      invAddrEn = ($urandom_range(0, 4) == 0);
      invAddr = segB($urandom_range(0, 7), 0, 0);
    end
    idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule